// File: doc/BRIEF.md
# Posted CAS Data Window Scheduler and Burst Rule Checker

This block sits beside a memory controller's command path and watches the column commands it issues to a double-data-rate memory that uses posted CAS timing. It is programmed with an additive latency, a CAS latency and a burst length of 4 or 8. For each accepted read it raises a read data window, and for each accepted write a write data window. Each window opens at the latency that applies to its command type and stays open for as many clock cycles as the burst needs at double data rate.

Alongside the scheduling, the block enforces the rules for interrupting a burst. It flags an error when a column command cuts into a burst that may not be cut. It also flags a burst stop command, a column command to a bank that was never activated, and a latency setting outside the supported range. A rejected column command schedules no window. A bank is opened by an activate command and stays open. Activate-to-column spacing is not checked, so a column command may follow its activate on the very next clock.

Top module: `posted_cas_sched`

## Requirements
- R1: A read accepted at clock edge P opens rdWindow after edge P+RL, where RL = addLat + casLat.
- R2: A write accepted at clock edge P opens wrWindow after edge P+RL-1, one cycle earlier than a read.
- R3: A window from a lone command stays high for exactly 2 cycles when burstLen8 = 0 (4-beat burst) and for exactly 4 cycles when burstLen8 = 1 (8-beat burst).
- R4: A column command accepted exactly burst/2 cycles after the previous accepted one is not an interruption. Its window follows the earlier window with no gap and no error.
- R5: With 4-beat bursts, a column command arriving fewer than 2 cycles after the previous accepted column command raises the error and is dropped.
- R6: With 8-beat bursts, a read that interrupts a read, or a write that interrupts a write, is accepted. The earlier window ends where the new window begins, and the new window then runs its full 4 cycles.
- R7: With 8-beat bursts, a write that arrives fewer than 4 cycles after an accepted read, or a read that arrives that soon after an accepted write, raises the error and is dropped.
- R8: cmdType encoding is 0 = read, 1 = write, 2 = burst stop, 3 = activate. A burst stop always raises the error.
- R9: If addLat > 4, casLat < 3 or casLat > 6, errFlag is high on every cycle and column commands schedule nothing. Once a legal setting is restored, errFlag clears.
- R10: A column command to a bank that has not been activated since reset raises the error and is dropped. A column command one cycle after its bank's activate is accepted.
- R11: errFlag is registered. A single offending command at edge P makes it high for exactly the one cycle after P.
- R12: After reset, rdWindow, wrWindow and errFlag are low and every bank is closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| addLat | input | 3 | Programmed additive latency |
| casLat | input | 3 | Programmed CAS latency |
| burstLen8 | input | 1 | 1 selects 8-beat bursts, 0 selects 4-beat bursts |
| cmdValid | input | 1 | A command is present this cycle |
| cmdType | input | 2 | 0 read, 1 write, 2 burst stop, 3 activate |
| cmdBank | input | 2 | Target bank of the command |
| rdWindow | output | 1 | High while read data is on the bus |
| wrWindow | output | 1 | High while write data is on the bus |
| errFlag | output | 1 | Registered error pulse for an illegal command or setting |

## Verification
The hardest case to reach from the ports is the truncating interruption. A second command of the same type must land inside the first burst's spacing while the first burst's data is still in the latency pipeline, so both bursts are in flight at once. The stimulus issues a pair of commands with a chosen gap of 1, 2 or 4 cycles from a single sampling task. It then counts how many cycles each window is high and where it starts. A one-cycle gap between two writes gives a 5-cycle window only when the earlier window is cut at the moment the new one opens. Cross-type pairs at the same gaps confirm that the rejected command leaves no window behind.

// File: rtl/posted_cas_pkg.sv
package posted_cas_pkg;
  localparam int LAT_W  = 3;
  localparam int RL_W   = 4;
  localparam int CNT_W  = 3;
  localparam logic [LAT_W-1:0] MAX_AL = 3'd4;
  localparam logic [LAT_W-1:0] MIN_CL = 3'd3;
  localparam logic [LAT_W-1:0] MAX_CL = 3'd6;
  localparam int MAX_RL = int'(MAX_AL) + int'(MAX_CL);

  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_STOP  = 2'd2,
    CMD_ACT   = 2'd3
  } cmdT;

  typedef struct packed {
    logic schedRd;
    logic schedWr;
  } strobeT;
endpackage

// File: rtl/posted_cas_ctrl.sv
module posted_cas_ctrl
  import posted_cas_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LAT_W-1:0]  addLat,
  input  logic [LAT_W-1:0]  casLat,
  input  logic              burstLen8,
  input  logic              cmdValid,
  input  logic [1:0]        cmdType,
  input  logic [BANK_W-1:0] cmdBank,
  output strobeT            strobe,
  output logic              errFlag
);
  localparam logic [CNT_W-1:0] SINCE_SAT = '1;

  logic [BANKS-1:0] bankOpen;
  logic [CNT_W-1:0] sinceCol;
  logic             lastIsWr;
  logic [CNT_W-1:0] halfBeats;
  logic             cfgBad, isRd, isWr, isStop, isAct, isCol;
  logic             overlapping, sameType, colErr, accept;

  always_comb begin
    halfBeats   = burstLen8 ? CNT_W'(4) : CNT_W'(2);
    cfgBad      = (addLat > MAX_AL) || (casLat < MIN_CL) || (casLat > MAX_CL);
    isRd        = cmdValid && (cmdT'(cmdType) == CMD_READ);
    isWr        = cmdValid && (cmdT'(cmdType) == CMD_WRITE);
    isStop      = cmdValid && (cmdT'(cmdType) == CMD_STOP);
    isAct       = cmdValid && (cmdT'(cmdType) == CMD_ACT);
    isCol       = isRd || isWr;
    overlapping = sinceCol < halfBeats;
    sameType    = (isWr == lastIsWr);
    colErr      = isCol && (cfgBad || !bankOpen[cmdBank] ||
                            (overlapping && !(burstLen8 && sameType)));
    accept      = isCol && !colErr;
    strobe.schedRd = accept && isRd;
    strobe.schedWr = accept && isWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankOpen <= '0;
      sinceCol <= SINCE_SAT;
      lastIsWr <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      errFlag <= cfgBad || isStop || colErr;
      if (isAct) bankOpen[cmdBank] <= 1'b1;
      if (accept) begin
        sinceCol <= CNT_W'(1);
        lastIsWr <= isWr;
      end else if (sinceCol != SINCE_SAT) begin
        sinceCol <= sinceCol + CNT_W'(1);
      end
    end
  end

  // R6: never both channels scheduled from one command
  assert_one_sched_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.schedRd, strobe.schedWr}));

  // R8: a burst stop is reported on the next cycle
  assert_stop_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    isStop |=> errFlag);

  // R5: with 4-beat bursts no accepted command is closer than 2 cycles
  assert_bl4_spacing_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !burstLen8) |-> (sinceCol >= CNT_W'(2)));

  // R7: an accepted overlapping command is of the same type as the last one
  assert_same_type_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accept && sinceCol < CNT_W'(4)) |-> (isWr == lastIsWr || !burstLen8));

  // R10: accepted commands only target opened banks
  assert_open_bank_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.schedRd || strobe.schedWr) |-> bankOpen[cmdBank]);
endmodule

// File: rtl/posted_cas_datapath.sv
module posted_cas_datapath
  import posted_cas_pkg::*;
#(
  parameter int PIPE_D = MAX_RL
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LAT_W-1:0] addLat,
  input  logic [LAT_W-1:0] casLat,
  input  logic             burstLen8,
  input  strobeT           strobe,
  output logic             rdWindow,
  output logic             wrWindow
);
  localparam int CHANNELS = 2;

  logic [RL_W-1:0]     readLat;
  logic [CNT_W-1:0]    halfBeats;
  logic [CHANNELS-1:0] win;

  assign readLat   = RL_W'(addLat) + RL_W'(casLat);
  assign halfBeats = burstLen8 ? CNT_W'(4) : CNT_W'(2);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    logic [PIPE_D-1:0] pipe;
    logic [CNT_W-1:0]  beatCnt;
    logic              sched;
    logic [RL_W-1:0]   slot;

    assign sched = (c == 0) ? strobe.schedRd : strobe.schedWr;
    // channel 0 lands at RL, channel 1 at RL-1; the pipe head loads the counter
    assign slot  = readLat - RL_W'(c + 1);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pipe    <= '0;
        beatCnt <= '0;
      end else begin
        pipe <= {1'b0, pipe[PIPE_D-1:1]} |
                (sched ? (PIPE_D'(1) << slot) : '0);
        if (pipe[0])                beatCnt <= halfBeats;
        else if (beatCnt != '0)     beatCnt <= beatCnt - CNT_W'(1);
      end
    end

    assign win[c] = (beatCnt != '0);

    // R3: a window never runs longer than an 8-beat burst
    assert_beat_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
      beatCnt <= CNT_W'(4));
  end

  assign rdWindow = win[0];
  assign wrWindow = win[1];
endmodule

// File: rtl/posted_cas_sched.sv
module posted_cas_sched
  import posted_cas_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        addLat,
  input  logic [2:0]        casLat,
  input  logic              burstLen8,
  input  logic              cmdValid,
  input  logic [1:0]        cmdType,
  input  logic [BANK_W-1:0] cmdBank,
  output logic              rdWindow,
  output logic              wrWindow,
  output logic              errFlag
);
  strobeT strobe;

  posted_cas_ctrl #(.BANKS(BANKS), .BANK_W(BANK_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .addLat(addLat), .casLat(casLat),
    .burstLen8(burstLen8), .cmdValid(cmdValid), .cmdType(cmdType),
    .cmdBank(cmdBank), .strobe(strobe), .errFlag(errFlag)
  );

  posted_cas_datapath #(.PIPE_D(MAX_RL)) dp_i (
    .clk(clk), .rstN(rstN), .addLat(addLat), .casLat(casLat),
    .burstLen8(burstLen8), .strobe(strobe),
    .rdWindow(rdWindow), .wrWindow(wrWindow)
  );
endmodule

// File: tb/posted_cas_sched_tb.sv
`timescale 1ns/1ps
module posted_cas_sched_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] addLat, casLat;
  logic       burstLen8, cmdValid;
  logic [1:0] cmdType, cmdBank;
  logic       rdWindow, wrWindow, errFlag;

  int checks = 0;
  int fails  = 0;
  int rdFirst, rdCnt, wrFirst, wrCnt;
  logic [24:0] errMask;

  always #4 clk = ~clk;

  posted_cas_sched dut_i (
    .clk(clk), .rstN(rstN), .addLat(addLat), .casLat(casLat),
    .burstLen8(burstLen8), .cmdValid(cmdValid), .cmdType(cmdType),
    .cmdBank(cmdBank), .rdWindow(rdWindow), .wrWindow(wrWindow),
    .errFlag(errFlag)
  );

  // {al[16:14], cl[13:11], bl8[10], wr[9], first[8:4], len[3:0]}
  localparam logic [16:0] VEC [8] = '{
    {3'd2, 3'd3, 1'b0, 1'b0, 5'd5,  4'd2},
    {3'd2, 3'd3, 1'b0, 1'b1, 5'd4,  4'd2},
    {3'd0, 3'd3, 1'b0, 1'b0, 5'd3,  4'd2},
    {3'd0, 3'd3, 1'b1, 1'b1, 5'd2,  4'd4},
    {3'd4, 3'd6, 1'b1, 1'b0, 5'd10, 4'd4},
    {3'd4, 3'd6, 1'b0, 1'b1, 5'd9,  4'd2},
    {3'd1, 3'd4, 1'b1, 1'b1, 5'd4,  4'd4},
    {3'd3, 3'd5, 1'b1, 1'b0, 5'd8,  4'd4}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    cmdValid = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  task automatic setCfg(input logic [2:0] al, input logic [2:0] cl, input logic bl8);
    addLat = al; casLat = cl; burstLen8 = bl8;
  endtask

  // Command A at edge P0, optional B at edge P0+gap; sample after edges 0..24
  task automatic run(input logic [1:0] tA, input logic [1:0] bA, input int gap,
                     input logic [1:0] tB, input logic [1:0] bB);
    rdFirst = -1; wrFirst = -1; rdCnt = 0; wrCnt = 0; errMask = '0;
    @(negedge clk);
    cmdValid = 1'b1; cmdType = tA; cmdBank = bA;
    for (int k = 0; k <= 24; k++) begin
      @(negedge clk);
      if (rdWindow) begin rdCnt++; if (rdFirst < 0) rdFirst = k; end
      if (wrWindow) begin wrCnt++; if (wrFirst < 0) wrFirst = k; end
      errMask[k] = errFlag;
      if (gap > 0 && k + 1 == gap) begin
        cmdValid = 1'b1; cmdType = tB; cmdBank = bB;
      end else begin
        cmdValid = 1'b0;
      end
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmdType = 2'd0; cmdBank = 2'd0;
    setCfg(3'd2, 3'd3, 1'b0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12: reset state
    check(rdWindow == 1'b0, "R12 rdWindow after reset", rdWindow, 0);
    check(wrWindow == 1'b0, "R12 wrWindow after reset", wrWindow, 0);
    check(errFlag == 1'b0, "R12 errFlag after reset", errFlag, 0);

    // R10 / R12: read to a bank closed since reset is rejected
    run(2'd0, 2'd1, 0, 2'd0, 2'd0);
    check(errMask == 25'd1, "R10 closed bank error pulse", int'(errMask), 1);
    check(rdCnt == 0, "R10 closed bank no window", rdCnt, 0);
    idle();
    // R10: activate then read on the next cycle, AL2 CL3 -> RL5 after read edge
    run(2'd3, 2'd1, 1, 2'd0, 2'd1);
    check(errMask == 25'd0, "R10 read after activate no error", int'(errMask), 0);
    check(rdFirst == 6, "R10 read after activate start", rdFirst, 6);
    check(rdCnt == 2, "R10 read after activate length", rdCnt, 2);
    idle();
    for (int b = 0; b < 4; b++) begin
      run(2'd3, 2'(b), 0, 2'd0, 2'd0);
      idle();
    end

    // R1, R2, R3: table of latency and burst settings
    for (int i = 0; i < 8; i++) begin
      setCfg(VEC[i][16:14], VEC[i][13:11], VEC[i][10]);
      idle();
      run(VEC[i][9] ? 2'd1 : 2'd0, 2'(i % 4), 0, 2'd0, 2'd0);
      if (VEC[i][9]) begin
        check(wrFirst == int'(VEC[i][8:4]), "R2 write window start", wrFirst, int'(VEC[i][8:4]));
        check(wrCnt == int'(VEC[i][3:0]), "R3 write window length", wrCnt, int'(VEC[i][3:0]));
        check(rdCnt == 0, "R2 no read window on write", rdCnt, 0);
      end else begin
        check(rdFirst == int'(VEC[i][8:4]), "R1 read window start", rdFirst, int'(VEC[i][8:4]));
        check(rdCnt == int'(VEC[i][3:0]), "R3 read window length", rdCnt, int'(VEC[i][3:0]));
        check(wrCnt == 0, "R1 no write window on read", wrCnt, 0);
      end
      check(errMask == 25'd0, "R1 no error on legal command", int'(errMask), 0);
    end

    // R4: seamless reads, 4-beat bursts, gap 2
    setCfg(3'd0, 3'd3, 1'b0); idle();
    run(2'd0, 2'd0, 2, 2'd0, 2'd2);
    check(rdFirst == 3 && rdCnt == 4, "R4 seamless 4-beat reads", rdCnt, 4);
    check(errMask == 25'd0, "R4 seamless no error", int'(errMask), 0);
    // R4: seamless writes, 8-beat bursts, gap 4
    setCfg(3'd0, 3'd3, 1'b1); idle();
    run(2'd1, 2'd0, 4, 2'd1, 2'd1);
    check(wrFirst == 2 && wrCnt == 8, "R4 seamless 8-beat writes", wrCnt, 8);

    // R5: 4-beat interruption rejected
    setCfg(3'd0, 3'd3, 1'b0); idle();
    run(2'd0, 2'd0, 1, 2'd0, 2'd0);
    check(errMask == 25'd2, "R5 read on read error", int'(errMask), 2);
    check(rdCnt == 2, "R5 second read dropped", rdCnt, 2);
    idle();
    run(2'd1, 2'd0, 1, 2'd0, 2'd0);
    check(errMask == 25'd2 && rdCnt == 0, "R5 read on write rejected", rdCnt, 0);

    // R6: 8-beat same-type interruptions truncate
    setCfg(3'd0, 3'd3, 1'b1); idle();
    run(2'd0, 2'd0, 2, 2'd0, 2'd0);
    check(errMask == 25'd0, "R6 read on read no error", int'(errMask), 0);
    check(rdFirst == 3 && rdCnt == 6, "R6 read on read window", rdCnt, 6);
    idle();
    run(2'd1, 2'd0, 1, 2'd1, 2'd0);
    check(wrFirst == 2 && wrCnt == 5, "R6 write on write truncation", wrCnt, 5);

    // R7: 8-beat cross-type interruptions rejected
    idle();
    run(2'd0, 2'd0, 2, 2'd1, 2'd0);
    check(errMask == 25'd4, "R7 write on read error", int'(errMask), 4);
    check(wrCnt == 0 && rdCnt == 4, "R7 write dropped read intact", wrCnt, 0);
    idle();
    run(2'd1, 2'd0, 3, 2'd0, 2'd0);
    check(errMask == 25'd8 && rdCnt == 0, "R7 read on write rejected", rdCnt, 0);

    // R8, R11: burst stop gives a one-cycle error pulse
    idle();
    run(2'd2, 2'd0, 0, 2'd0, 2'd0);
    check(errMask == 25'd1, "R8 R11 burst stop pulse", int'(errMask), 1);

    // R9: illegal latency settings
    setCfg(3'd5, 3'd3, 1'b0); idle();
    run(2'd0, 2'd0, 0, 2'd0, 2'd0);
    check(errMask == 25'h1FFFFFF, "R9 additive latency too large", int'(errMask), 'h1FFFFFF);
    check(rdCnt == 0, "R9 read dropped", rdCnt, 0);
    setCfg(3'd0, 3'd2, 1'b0);
    run(2'd1, 2'd0, 0, 2'd0, 2'd0);
    check(errMask == 25'h1FFFFFF && wrCnt == 0, "R9 CAS latency too small", wrCnt, 0);
    setCfg(3'd0, 3'd7, 1'b0);
    run(2'd0, 2'd0, 0, 2'd0, 2'd0);
    check(errMask == 25'h1FFFFFF && rdCnt == 0, "R9 CAS latency too large", rdCnt, 0);
    setCfg(3'd0, 3'd3, 1'b0);
    repeat (2) @(negedge clk);
    check(errFlag == 1'b0, "R9 error clears on legal setting", errFlag, 0);

    finishRun();
  end
endmodule